// File: doc/BRIEF.md
# Call/Return Stack-Frame Sequencer

This block carries out subroutine call and return for a 32-bit processor whose register file keeps the frame pointer in register 0 and the stack pointer in register 1. The surrounding pipeline presents a start pulse with an operation code, the address of the call instruction, and the call target. The block reads the current frame and stack pointers, moves the frame words through a word-wide memory port, and updates the frame pointer, stack pointer and PC together in one commit cycle.

A call builds a three-word frame below the current stack pointer. The highest word is a static-chain slot that the call skips over and never writes. The word under it receives the return address, and the lowest word receives the caller's frame pointer. The new frame pointer and the new stack pointer both point at that lowest word. A return works from the frame pointer alone. It reloads the caller's frame pointer and the return PC from the frame, and it places the stack pointer just above the frame. A memory fault on any access stops the sequence and leaves all three registers as they were.

Top module: `frame_seq`

## Requirements
- R1: After reset the block is idle: `mem_req`, `done`, `fault`, `fp_we`, `sp_we` and `pc_we` are all 0.
- R2: A call (op 0 or op 1) first writes the return address to the word at SP-8. It never writes the static-chain word at SP-4.
- R3: After the return-address write succeeds, the call writes the old FP to the word at SP-12. The second access address is 4 below the first.
- R4: A call ends in a single commit cycle. In that cycle `fp_we`, `sp_we` and `pc_we` are all 1 together with `done`. SP and FP become SP-12, and PC becomes `target`.
- R5: The return address is `insn_addr`+6 for op 0 (call to an absolute target). It is `insn_addr`+2 for op 1 (call through a register).
- R6: A return (op 2) reads the word at FP and then the word at FP+4. It sets FP to the first word read, PC to the second word read, and SP to the original FP+12.
- R7: If `mem_fault` is 1 with `mem_ack` on any access, the sequence stops. In the next cycle `done` and `fault` are both 1, and FP, SP and PC are not written.
- R8: A start with op 3 is ignored: no memory access, no `done`, no register write. A start while a sequence is running is also ignored.
- R9: `mem_req` stays asserted, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`. Each state performs exactly one word access.
- R10: With every access acknowledged in its first cycle, `done` is 1 in the third cycle after the start is accepted, for both calls and returns. Each memory wait cycle adds one cycle.
- R11: Stack words are 32-bit big-endian words. The byte at the lowest address travels on bits 31:24 of `mem_wdata` and `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (sampled when idle) |
| op | input | 2 | 0 call absolute, 1 call via register, 2 return, 3 no-op |
| insn_addr | input | 32 | Address of the call instruction |
| target | input | 32 | Call destination address |
| fp_rdata | input | 32 | Current frame pointer (register 0) |
| sp_rdata | input | 32 | Current stack pointer (register 1) |
| fp_we | output | 1 | Frame pointer write enable |
| fp_wdata | output | 32 | New frame pointer |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 32 | New stack pointer |
| pc_we | output | 1 | PC write enable |
| pc_wdata | output | 32 | New PC |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write word, big-endian |
| mem_rdata | input | 32 | Read word, big-endian |
| mem_ack | input | 1 | Access complete |
| mem_fault | input | 1 | Access failed (valid with mem_ack) |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| fault | output | 1 | Sequence aborted by a memory fault (with done) |

## Verification
Some properties are checked by assertions on every cycle. Requests hold steady until acknowledged. A successful push is followed by a push 4 bytes lower, and a successful pop by a pop 4 bytes higher. A faulted access is followed by done and fault with no register write. The three write enables rise only together with done. The directed scenarios cover what a cycle-local property cannot show. These are the frame contents left in memory, the untouched static-chain slot, the return-address offsets of the two call forms, and the register values after a call followed by nested returns. The scenarios also cover the cycle on which done appears with and without memory wait states, and the fact that no-op and mid-sequence starts leave no trace.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    OP_CALL_ABS = 2'd0,
    OP_CALL_REG = 2'd1,
    OP_RET      = 2'd2,
    OP_NONE     = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WR_RA  = 3'd1,
    ST_WR_FP  = 3'd2,
    ST_RD_FP  = 3'd3,
    ST_RD_PC  = 3'd4,
    ST_COMMIT = 3'd5
  } seq_st_e;
endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  seq_op_e op,
  input  logic    mem_ack,
  input  logic    mem_fault,
  output seq_st_e st,
  output logic    accept,
  output logic    done,
  output logic    fault
);
  seq_st_e st_nx;
  logic    mem_phase, step_ok, abort;

  always_comb begin
    mem_phase = (st == ST_WR_RA) || (st == ST_WR_FP) ||
                (st == ST_RD_FP) || (st == ST_RD_PC);
    accept    = (st == ST_IDLE) && start && (op != OP_NONE);
    abort     = mem_phase && mem_ack && mem_fault;
    step_ok   = mem_phase && mem_ack && !mem_fault;
    st_nx     = st;
    case (st)
      ST_IDLE:   if (accept) st_nx = (op == OP_RET) ? ST_RD_FP : ST_WR_RA;
      ST_WR_RA:  if (step_ok) st_nx = ST_WR_FP;
      ST_WR_FP:  if (step_ok) st_nx = ST_COMMIT;
      ST_RD_FP:  if (step_ok) st_nx = ST_RD_PC;
      ST_RD_PC:  if (step_ok) st_nx = ST_COMMIT;
      ST_COMMIT: st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
    if (abort) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      st    <= st_nx;
      done  <= abort || ((st != ST_COMMIT) && (st_nx == ST_COMMIT));
      fault <= abort;
    end
  end
endmodule

// File: rtl/frame_seq_dp.sv
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int ABS_LEN     = 6,
  parameter int REG_LEN     = 2,
  parameter int FRAME_WORDS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_st_e         st,
  input  logic            accept,
  input  seq_op_e         op,
  input  logic [XLEN-1:0] insn_addr,
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] fp_rdata,
  input  logic [XLEN-1:0] sp_rdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            fp_we,
  output logic [XLEN-1:0] fp_wdata,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_wdata,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_wdata
);
  localparam int              WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] PC_OFF     = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] RA_OFF     = XLEN'(2 * WORD_BYTES);
  localparam logic [XLEN-1:0] FRAME_OFF  = XLEN'(FRAME_WORDS * WORD_BYTES);
  localparam logic [XLEN-1:0] ABS_STEP   = XLEN'(ABS_LEN);
  localparam logic [XLEN-1:0] REG_STEP   = XLEN'(REG_LEN);

  logic [XLEN-1:0] sp_q, fp_q, tgt_q, ra_q, ldfp_q, ldpc_q;
  logic            ret_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      fp_q   <= '0;
      tgt_q  <= '0;
      ra_q   <= '0;
      ldfp_q <= '0;
      ldpc_q <= '0;
      ret_q  <= 1'b0;
    end else begin
      if (accept) begin
        sp_q  <= sp_rdata;
        fp_q  <= fp_rdata;
        tgt_q <= target;
        ra_q  <= insn_addr + ((op == OP_CALL_ABS) ? ABS_STEP : REG_STEP);
        ret_q <= (op == OP_RET);
      end
      if (mem_ack && (st == ST_RD_FP)) ldfp_q <= mem_rdata;
      if (mem_ack && (st == ST_RD_PC)) ldpc_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_WR_RA: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = sp_q - RA_OFF; mem_wdata = ra_q;
      end
      ST_WR_FP: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = sp_q - FRAME_OFF; mem_wdata = fp_q;
      end
      ST_RD_FP: begin
        mem_req = 1'b1; mem_addr = fp_q;
      end
      ST_RD_PC: begin
        mem_req = 1'b1; mem_addr = fp_q + PC_OFF;
      end
      default: ;
    endcase
  end

  always_comb begin
    fp_we    = (st == ST_COMMIT);
    sp_we    = (st == ST_COMMIT);
    pc_we    = (st == ST_COMMIT);
    fp_wdata = ret_q ? ldfp_q : (sp_q - FRAME_OFF);
    sp_wdata = ret_q ? (fp_q + FRAME_OFF) : (sp_q - FRAME_OFF);
    pc_wdata = ret_q ? ldpc_q : tgt_q;
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int ABS_LEN     = 6,
  parameter int REG_LEN     = 2,
  parameter int FRAME_WORDS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] insn_addr,
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] fp_rdata,
  input  logic [XLEN-1:0] sp_rdata,
  output logic            fp_we,
  output logic [XLEN-1:0] fp_wdata,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_wdata,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack,
  input  logic            mem_fault,
  output logic            done,
  output logic            fault
);
  localparam logic [XLEN-1:0] WSTEP = XLEN'(XLEN / 8);

  seq_st_e st;
  seq_op_e op_e;
  logic    accept;

  assign op_e = seq_op_e'(op);

  frame_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op(op_e),
    .mem_ack(mem_ack), .mem_fault(mem_fault),
    .st(st), .accept(accept), .done(done), .fault(fault)
  );

  frame_seq_dp #(
    .XLEN(XLEN), .ABS_LEN(ABS_LEN), .REG_LEN(REG_LEN), .FRAME_WORDS(FRAME_WORDS)
  ) u_dp (
    .clk(clk), .rst(rst), .st(st), .accept(accept), .op(op_e),
    .insn_addr(insn_addr), .target(target),
    .fp_rdata(fp_rdata), .sp_rdata(sp_rdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fp_we(fp_we), .fp_wdata(fp_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  // R9: request and payload held until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R3: a successful push is followed only by a push one word lower
  assert_push_order_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack && !mem_fault) |=>
      (!mem_req || !mem_we || (mem_addr == $past(mem_addr) - WSTEP)));

  // R6: a successful pop is followed only by a pop one word higher
  assert_pop_order_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack && !mem_fault) |=>
      (!mem_req || mem_we || (mem_addr == $past(mem_addr) + WSTEP)));

  // R7: a faulted access ends the sequence without register writes
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_fault) |=> (done && fault && !fp_we && !sp_we && !pc_we));

  // R4: the three register writes happen together, only in the done cycle
  assert_commit_R4: assert property (@(posedge clk) disable iff (rst)
    (fp_we || sp_we || pc_we) |-> (fp_we && sp_we && pc_we && done && !fault));

  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd3;
  logic [31:0] insn_addr = '0, target = '0;
  logic [31:0] fp_r, sp_r, pc_r;
  logic        fp_we, sp_we, pc_we;
  logic [31:0] fp_wdata, sp_wdata, pc_wdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_fault = 1'b0;
  logic        done, fault;

  always #10 clk = ~clk;

  frame_seq u_frame_seq (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .insn_addr(insn_addr), .target(target),
    .fp_rdata(fp_r), .sp_rdata(sp_r),
    .fp_we(fp_we), .fp_wdata(fp_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_fault(mem_fault),
    .done(done), .fault(fault)
  );

  int total = 0, bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // register file model
  logic        ld = 1'b0;
  logic [31:0] ld_fp = '0, ld_sp = '0, ld_pc = '0;
  int          wr_cnt = 0;
  always @(posedge clk) begin
    if (ld) begin
      fp_r <= ld_fp; sp_r <= ld_sp; pc_r <= ld_pc;
    end else begin
      if (fp_we) fp_r <= fp_wdata;
      if (sp_we) sp_r <= sp_wdata;
      if (pc_we) pc_r <= pc_wdata;
      if (fp_we || sp_we || pc_we) wr_cnt <= wr_cnt + 1;
    end
  end

  // memory model: answers at the falling edge, optional wait states and fault
  logic [31:0] mem [0:63];
  int          wait_n = 0, wcnt = 0, acc_cnt = 0;
  logic        fault_en = 1'b0;
  logic [31:0] fault_addr = '0;
  logic [31:0] acc_addr [0:63];
  logic        acc_we   [0:63];
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | 32'(i);
      mem_ack = 1'b0; mem_fault = 1'b0; wcnt = 0; acc_cnt = 0;
    end else if (mem_req) begin
      if (wcnt == wait_n) begin
        mem_ack = 1'b1; wcnt = 0;
        acc_addr[acc_cnt % 64] = mem_addr;
        acc_we[acc_cnt % 64]   = mem_we;
        acc_cnt++;
        if (fault_en && mem_addr == fault_addr) mem_fault = 1'b1;
        else begin
          mem_fault = 1'b0;
          if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[7:2]];
        end
      end else begin
        mem_ack = 1'b0; mem_fault = 1'b0; wcnt++;
      end
    end else begin
      mem_ack = 1'b0; mem_fault = 1'b0; wcnt = 0;
    end
  end

  task automatic preload(logic [31:0] f, logic [31:0] s, logic [31:0] p);
    @(negedge clk);
    ld_fp = f; ld_sp = s; ld_pc = p; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  // start one operation, return cycles to done and the fault flag seen with done
  task automatic run_op(logic [1:0] o, logic [31:0] ia, logic [31:0] tg,
                        output int cyc, output logic flt);
    @(negedge clk);
    start = 1'b1; op = o; insn_addr = ia; target = tg;
    cyc = 0; flt = 1'b0;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    flt = fault;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 fault", {31'd0, fault}, 32'd0);
    chk("R1 we", {29'd0, fp_we, sp_we, pc_we}, 32'd0);
  endtask

  task automatic t_call_abs();
    int c; logic f; int a0;
    preload(32'h44, 32'hF0, 32'h1000);
    a0 = acc_cnt;
    run_op(2'd0, 32'h1000, 32'h2000, c, f);
    chk("R10 call cycles", 32'(c), 32'd3);
    chk("R2 first addr", acc_addr[a0 % 64], 32'hE8);
    chk("R3 second addr", acc_addr[(a0 + 1) % 64], 32'hE4);
    chk("R5 abs return addr", mem[58], 32'h1006);
    chk("R3 saved fp", mem[57], 32'h44);
    chk("R2 static slot untouched", mem[59], 32'hA500_003B);
    chk("R4 sp", sp_r, 32'hE4);
    chk("R4 fp", fp_r, 32'hE4);
    chk("R4 pc", pc_r, 32'h2000);
    chk("R11 byte lane", {24'd0, mem[58][31:24]}, 32'h00);
  endtask

  task automatic t_call_reg();
    int c; logic f;
    run_op(2'd1, 32'h1100, 32'h3000, c, f);
    chk("R10 reg call cycles", 32'(c), 32'd3);
    chk("R5 reg return addr", mem[55], 32'h1102);
    chk("R3 nested saved fp", mem[54], 32'hE4);
    chk("R4 nested sp", sp_r, 32'hD8);
    chk("R4 nested fp", fp_r, 32'hD8);
    chk("R4 nested pc", pc_r, 32'h3000);
  endtask

  task automatic t_ret();
    int c; logic f; int a0;
    a0 = acc_cnt;
    run_op(2'd2, 32'h0, 32'h0, c, f);
    chk("R10 ret cycles", 32'(c), 32'd3);
    chk("R6 first read", acc_addr[a0 % 64], 32'hD8);
    chk("R6 second read", acc_addr[(a0 + 1) % 64], 32'hDC);
    chk("R6 reads are reads", {31'd0, acc_we[a0 % 64] | acc_we[(a0 + 1) % 64]}, 32'd0);
    chk("R6 fp", fp_r, 32'hE4);
    chk("R6 pc", pc_r, 32'h1102);
    chk("R6 sp", sp_r, 32'hE4);
  endtask

  task automatic t_ret_wait();
    int c; logic f;
    wait_n = 2;
    run_op(2'd2, 32'h0, 32'h0, c, f);
    wait_n = 0;
    chk("R9 ret with waits cycles", 32'(c), 32'd7);
    chk("R6 outer fp", fp_r, 32'h44);
    chk("R6 outer pc", pc_r, 32'h1006);
    chk("R6 outer sp", sp_r, 32'hF0);
  endtask

  task automatic t_fault_push();
    int c; logic f; int w0;
    preload(32'h44, 32'hF0, 32'h1234);
    w0 = wr_cnt;
    fault_en = 1'b1; fault_addr = 32'hE4;
    run_op(2'd0, 32'h1000, 32'h5000, c, f);
    fault_en = 1'b0;
    chk("R7 abort cycles", 32'(c), 32'd3);
    chk("R7 fault flag", {31'd0, f}, 32'd1);
    chk("R7 no reg write", 32'(wr_cnt - w0), 32'd0);
    chk("R7 sp kept", sp_r, 32'hF0);
    chk("R7 fp kept", fp_r, 32'h44);
    chk("R7 pc kept", pc_r, 32'h1234);
  endtask

  task automatic t_fault_pop();
    int c; logic f;
    fault_en = 1'b1; fault_addr = 32'h44;
    run_op(2'd2, 32'h0, 32'h0, c, f);
    fault_en = 1'b0;
    chk("R7 pop abort cycles", 32'(c), 32'd2);
    chk("R7 pop fault flag", {31'd0, f}, 32'd1);
    chk("R7 pop fp kept", fp_r, 32'h44);
    chk("R7 pop pc kept", pc_r, 32'h1234);
  endtask

  task automatic t_noop();
    int a0, w0; int seen;
    a0 = acc_cnt; w0 = wr_cnt; seen = 0;
    @(negedge clk);
    start = 1'b1; op = 2'd3;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (done || mem_req) seen++;
      @(negedge clk);
    end
    chk("R8 op3 no activity", 32'(seen), 32'd0);
    chk("R8 op3 no access", 32'(acc_cnt - a0), 32'd0);
    chk("R8 op3 no write", 32'(wr_cnt - w0), 32'd0);
  endtask

  task automatic t_busy();
    int a0; int c;
    preload(32'h60, 32'hC0, 32'h0);
    a0 = acc_cnt;
    @(negedge clk);
    start = 1'b1; op = 2'd1; insn_addr = 32'h2000; target = 32'h7000;
    @(negedge clk);
    op = 2'd2; c = 1;
    @(negedge clk);
    start = 1'b0; c = 2;
    while (!done && c < 60) begin
      @(negedge clk);
      c++;
    end
    repeat (8) @(negedge clk);
    chk("R8 busy start ignored accesses", 32'(acc_cnt - a0), 32'd2);
    chk("R8 busy sp", sp_r, 32'hB4);
    chk("R8 busy fp", fp_r, 32'hB4);
    chk("R8 busy pc", pc_r, 32'h7000);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_call_abs();
    t_call_reg();
    t_ret();
    t_ret_wait();
    t_fault_push();
    t_fault_pop();
    t_noop();
    t_busy();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule